// File: doc/BRIEF.md
# Lockable Cartridge Bank-Swap Mapper

This block sits on the cartridge side of a 68000-style bus with a 24-bit byte address. It holds a single 8-bit control byte that is written by ordinary bus writes into a small slice of the lowest 64 KB of cartridge space. Two of its bits matter. The swap bit exchanges the lowest 256 KB ROM window for a high ROM bank and also opens a second window onto battery RAM. The lock bit, once it is set, freezes the control byte until the next reset.

For every bus cycle the block decodes the address combinationally from the latched control byte. It produces a translated ROM address with a ROM select, and a RAM offset with a RAM select. The ROM and RAM arrays are outside the block. The control byte can also be observed on a debug output.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write cycle (`bus_valid`=1, `bus_write`=1) updates the control byte with `bus_wdata` only when its effective address has bits [23:16] = 0x00 and bits [11:8] = 0xE. Any other write leaves the control byte unchanged.
- R2: For a byte write (`bus_word`=0) the effective address is `bus_addr`. For a word write (`bus_word`=1) it is `bus_addr`+1, modulo 2^24. For example, a word write at 0x000DFF is accepted, a byte write at 0x000DFF is rejected, and a word write at 0x00FFFF is rejected.
- R3: While control bit 5 (lock) is 1, every write leaves the control byte unchanged until reset.
- R4: With control bit 7 (swap) = 1, a read at 0x000000–0x03FFFF asserts `rom_sel` with `rom_addr` = 0x380000 + `bus_addr`[17:0].
- R5: With control bit 7 = 1, any cycle at 0x3C0000–0x3FFFFF asserts `ram_sel` with `ram_addr` = `bus_addr`[15:0], and `rom_sel` stays 0.
- R6: With control bit 7 = 0, a read at 0x000000–0x3FFFFF asserts `rom_sel` with `rom_addr` = `bus_addr`[21:0], and `ram_sel` stays 0 there.
- R7: Any cycle at 0x400000–0x40FFFF asserts `ram_sel` with `ram_addr` = `bus_addr`[15:0], whatever the control byte holds.
- R8: `rom_sel` is never asserted on a write cycle. Neither select is asserted when `bus_valid`=0, and neither is asserted for an address outside the ROM and RAM windows. `rom_sel` and `ram_sel` are never both 1.
- R9: A clock edge with `rst_n`=0 clears the control byte to 0x00, which gives the linear mapping. `ctrl_dbg` always shows the control byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is in progress |
| bus_write | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 8 | Low data lane; the only lane the control byte sees |
| rom_sel | output | 1 | ROM read select |
| rom_addr | output | 22 | Translated ROM byte offset |
| ram_sel | output | 1 | Battery RAM select |
| ram_addr | output | 16 | Battery RAM byte offset |
| ctrl_dbg | output | 8 | Current control byte |

## Verification
A wrong control byte is visible on `ctrl_dbg` one edge after the write that caused it. It also shows up in the same cycle as a wrong `rom_addr` or wrong selects on the next access to the low ROM window or to 0x3C0000. A missed or spurious lock only shows when a later write is accepted or refused, so the stimulus keeps writing to the control page after the lock is set. It also resets often, so that locked and unlocked phases both recur. The decode boundaries are aimed at with directed cycles: the carry of a word write into page 0xE, the 64 KB edge, and the edges of both RAM windows.

// File: rtl/cbm_pkg.sv
// Package: shared constants for the cartridge bank-swap mapper.
// Assumes a 24-bit byte address bus; all window positions are derived here.
package cbm_pkg;
    localparam int ADDR_W      = 24;     // bus byte address width
    localparam int ROM_AW      = 22;     // ROM offset width (4 MB space)
    localparam int BANK_AW     = 18;     // 256 KB bank offset width
    localparam int RAM_AW      = 16;     // battery RAM offset width
    localparam int CTRL_W      = 8;      // control byte width
    localparam int SWAP_BIT    = 7;      // control bit: bank swap + mirror
    localparam int LOCK_BIT    = 5;      // control bit: one-shot lock
    localparam int CTRL_PAGE   = 'hE;    // address bits [11:8] of the register
    localparam int SWAP_BANK   = 'hE;    // ROM bank brought down by the swap
    localparam int MIRROR_BANK = 'hF;    // bus bank holding the RAM mirror
    localparam int RAM_PAGE    = 'h40;   // bus bits above RAM_AW for primary RAM
endpackage

// File: rtl/cbm_ctrl_reg.sv
// Control register: decodes writes into the low 64 KB and latches the low
// data byte. Word writes are decoded at address+1. Once the lock bit is
// set, further writes are refused until synchronous reset.
// Assumes bus_addr, bus_word and wdata are stable around the rising edge.
module cbm_ctrl_reg #(
    parameter int ADDR_W    = 24,
    parameter int CTRL_W    = 8,
    parameter int LOCK_BIT  = 5,
    parameter int CTRL_PAGE = 'hE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              word,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl
);
    localparam int HI_W = ADDR_W - 16;

    logic [ADDR_W-1:0] eff_addr;
    logic              hit;

    // Effective decode address: word accesses land on the odd byte.
    always_comb begin
        eff_addr = addr + {{(ADDR_W-1){1'b0}}, word};
        hit      = (eff_addr[ADDR_W-1:16] == {HI_W{1'b0}}) &&
                   (eff_addr[11:8] == CTRL_PAGE[3:0]);
    end

    // Register update: reset clears, an unlocked hitting write loads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en && hit && !ctrl[LOCK_BIT])
            ctrl <= wdata;
    end
endmodule

// File: rtl/cbm_ram_decode.sv
// Battery RAM decode: the primary window is always open; the mirror window
// one bank below the primary window opens only while swap is set.
// MIRROR_EN = 0 builds the variant without a mirror.
module cbm_ram_decode #(
    parameter int ADDR_W      = 24,
    parameter int BANK_AW     = 18,
    parameter int RAM_AW      = 16,
    parameter int RAM_PAGE    = 'h40,
    parameter int MIRROR_BANK = 'hF,
    parameter bit MIRROR_EN   = 1'b1
) (
    input  logic              valid,
    input  logic              swap,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_mirror,
    output logic              ram_sel,
    output logic [RAM_AW-1:0] ram_addr
);
    localparam int PAGE_W = ADDR_W - RAM_AW;
    localparam int BANK_W = ADDR_W - BANK_AW;

    logic in_primary;

    // Primary window hit.
    always_comb in_primary = (addr[ADDR_W-1:RAM_AW] == RAM_PAGE[PAGE_W-1:0]);

    generate
        if (MIRROR_EN) begin : g_mirror
            // Mirror window hit, gated by the swap bit.
            always_comb in_mirror = swap &&
                (addr[ADDR_W-1:BANK_AW] == MIRROR_BANK[BANK_W-1:0]);
        end else begin : g_no_mirror
            // No mirror in this variant.
            always_comb in_mirror = 1'b0;
        end
    endgenerate

    // Select and offset; both windows use the low address bits directly.
    always_comb begin
        ram_sel  = valid && (in_primary || in_mirror);
        ram_addr = addr[RAM_AW-1:0];
    end
endmodule

// File: rtl/cbm_rom_xlat.sv
// ROM translation: the whole 4 MB ROM space is mapped linearly, except
// that the lowest bank is replaced by SWAP_BANK while swap is set and the
// RAM mirror window is taken away from ROM. Reads only.
module cbm_rom_xlat #(
    parameter int ADDR_W    = 24,
    parameter int ROM_AW    = 22,
    parameter int BANK_AW   = 18,
    parameter int SWAP_BANK = 'hE
) (
    input  logic              valid,
    input  logic              write,
    input  logic              swap,
    input  logic              in_mirror,
    input  logic [ADDR_W-1:0] addr,
    output logic              rom_sel,
    output logic [ROM_AW-1:0] rom_addr
);
    localparam int TOP_W  = ADDR_W - ROM_AW;
    localparam int IDX_W  = ROM_AW - BANK_AW;
    localparam int LOW0_W = ADDR_W - BANK_AW;

    logic in_rom;
    logic in_bank0;

    // Window decode.
    always_comb begin
        in_rom   = (addr[ADDR_W-1:ROM_AW] == {TOP_W{1'b0}});
        in_bank0 = (addr[ADDR_W-1:BANK_AW] == {LOW0_W{1'b0}});
    end

    // Select and translated offset.
    always_comb begin
        rom_sel = valid && !write && in_rom && !in_mirror;
        if (swap && in_bank0)
            rom_addr = {SWAP_BANK[IDX_W-1:0], addr[BANK_AW-1:0]};
        else
            rom_addr = addr[ROM_AW-1:0];
    end
endmodule

// File: rtl/cart_bank_mapper.sv
// Top: lockable cartridge bank-swap mapper. One control byte is written
// through the low 64 KB; its swap bit remaps ROM bank 0 and opens a RAM
// mirror, and its lock bit freezes it. The mapping outputs are
// combinational from the bus inputs and the latched byte.
module cart_bank_mapper
    import cbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CTRL_W-1:0] bus_wdata,
    output logic              rom_sel,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              ram_sel,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [CTRL_W-1:0] ctrl_dbg
);
    logic [CTRL_W-1:0] ctrl;
    logic              wr_en;
    logic              swap;
    logic              in_mirror;

    // Strobes derived from the bus and the latched byte.
    always_comb begin
        wr_en    = bus_valid && bus_write;
        swap     = ctrl[SWAP_BIT];
        ctrl_dbg = ctrl;
    end

    cbm_ctrl_reg #(
        .ADDR_W(ADDR_W), .CTRL_W(CTRL_W),
        .LOCK_BIT(LOCK_BIT), .CTRL_PAGE(CTRL_PAGE)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word(bus_word),
        .addr(bus_addr), .wdata(bus_wdata), .ctrl(ctrl)
    );

    cbm_ram_decode #(
        .ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .RAM_AW(RAM_AW),
        .RAM_PAGE(RAM_PAGE), .MIRROR_BANK(MIRROR_BANK), .MIRROR_EN(1'b1)
    ) u_ram (
        .valid(bus_valid), .swap(swap), .addr(bus_addr),
        .in_mirror(in_mirror), .ram_sel(ram_sel), .ram_addr(ram_addr)
    );

    cbm_rom_xlat #(
        .ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .BANK_AW(BANK_AW),
        .SWAP_BANK(SWAP_BANK)
    ) u_rom (
        .valid(bus_valid), .write(bus_write), .swap(swap),
        .in_mirror(in_mirror), .addr(bus_addr),
        .rom_sel(rom_sel), .rom_addr(rom_addr)
    );
endmodule

// File: rtl/cart_bank_mapper_chk.sv
// Checker: port-level properties of the mapper, bound to every instance.
module cart_bank_mapper_chk
    import cbm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic              bus_word,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CTRL_W-1:0] bus_wdata,
    input logic              rom_sel,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              ram_sel,
    input logic [RAM_AW-1:0] ram_addr,
    input logic [CTRL_W-1:0] ctrl_dbg
);
    // R1: unlocked byte write to the control page loads the data.
    assert_ctrl_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !bus_word && bus_addr[23:16] == 8'h00 &&
         bus_addr[11:8] == 4'hE && !ctrl_dbg[LOCK_BIT])
        |=> (ctrl_dbg == $past(bus_wdata)));

    // R1, R2: a byte write above the low 64 KB changes nothing.
    assert_far_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !bus_word && bus_addr[23:16] != 8'h00)
        |=> $stable(ctrl_dbg));

    // R3: lock holds the byte until reset.
    assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_dbg[LOCK_BIT] |=> $stable(ctrl_dbg));

    // R4: swapped low bank reads from the high bank.
    assert_swap_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_dbg[SWAP_BIT] && bus_valid && !bus_write && bus_addr[23:18] == 6'h00)
        |-> (rom_sel && rom_addr == {4'hE, bus_addr[17:0]}));

    // R5: mirror window goes to RAM while swapped.
    assert_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_dbg[SWAP_BIT] && bus_valid && bus_addr[23:18] == 6'h0F)
        |-> (ram_sel && !rom_sel && ram_addr == bus_addr[15:0]));

    // R7: primary RAM window is always open.
    assert_ram_primary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr[23:16] == 8'h40)
        |-> (ram_sel && ram_addr == bus_addr[15:0]));

    // R8: selects exclusive, no ROM select on writes.
    assert_sel_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_sel && ram_sel) && !(rom_sel && bus_write));

    // R9: reset clears the control byte.
    assert_reset_clear_R9: assert property (@(posedge clk)
        (!rst_n) |=> (ctrl_dbg == 8'h00));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk u_chk (.*);

// File: tb/cart_bank_mapper_tb.sv
// Bench: directed corner cases, then seeded random cycles with periodic
// resets, against a bench-side model of the control byte.
module cart_bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_word = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        rom_sel, ram_sel;
    logic [21:0] rom_addr;
    logic [15:0] ram_addr;
    logic [7:0]  ctrl_dbg;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    logic [7:0] m_ctrl = 8'h00;

    always #2.5 clk = ~clk;

    cart_bank_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rom_sel(rom_sel), .rom_addr(rom_addr), .ram_sel(ram_sel),
        .ram_addr(ram_addr), .ctrl_dbg(ctrl_dbg)
    );

    // Requirement-level model of a register write (R1, R2, R3).
    function automatic logic [7:0] next_ctrl(logic [7:0] c, logic v, logic w,
                                             logic wd, logic [23:0] a, logic [7:0] d);
        logic [23:0] e;
        e = wd ? a + 24'd1 : a;
        if (v && w && !c[5] && e[23:16] == 8'h00 && e[11:8] == 4'hE) return d;
        return c;
    endfunction

    function automatic logic exp_mirror(logic [7:0] c, logic [23:0] a);
        return c[7] && a[23:18] == 6'h0F;
    endfunction

    function automatic logic exp_ram_sel(logic [7:0] c, logic v, logic [23:0] a);
        return v && (a[23:16] == 8'h40 || exp_mirror(c, a));
    endfunction

    function automatic logic exp_rom_sel(logic [7:0] c, logic v, logic w, logic [23:0] a);
        return v && !w && a[23:22] == 2'b00 && !exp_mirror(c, a);
    endfunction

    function automatic logic [21:0] exp_rom_addr(logic [7:0] c, logic [23:0] a);
        if (c[7] && a[23:18] == 6'h00) return {4'hE, a[17:0]};
        return a[21:0];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h time=%0t", req, act, exp, $time);
        end
    endtask

    // One bus cycle: check the byte, drive, check mapping, take the edge.
    task automatic cyc(logic v, logic w, logic wd, logic [23:0] a, logic [7:0] d);
        string tag;
        @(negedge clk);
        check("R1/R3 ctrl_dbg", {24'd0, ctrl_dbg}, {24'd0, m_ctrl});
        bus_valid = v; bus_write = w; bus_word = wd; bus_addr = a; bus_wdata = d;
        #1;
        if (a[23:16] == 8'h40)             tag = "R7";
        else if (exp_mirror(m_ctrl, a))    tag = "R5";
        else if (m_ctrl[7] && a[23:18] == 0) tag = "R4";
        else if (a[23:22] == 0)            tag = "R6";
        else                               tag = "R8";
        check({tag, " rom_sel"}, {31'd0, rom_sel}, {31'd0, exp_rom_sel(m_ctrl, v, w, a)});
        check({tag, " ram_sel"}, {31'd0, ram_sel}, {31'd0, exp_ram_sel(m_ctrl, v, a)});
        if (exp_rom_sel(m_ctrl, v, w, a))
            check({tag, " rom_addr"}, {10'd0, rom_addr}, {10'd0, exp_rom_addr(m_ctrl, a)});
        if (exp_ram_sel(m_ctrl, v, a))
            check({tag, " ram_addr"}, {16'd0, ram_addr}, {16'd0, a[15:0]});
        m_ctrl = next_ctrl(m_ctrl, v, w, wd, a, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_ctrl = 8'h00;
    endtask

    function automatic logic [23:0] rand_addr();
        logic [23:0] r;
        r = 24'($urandom);
        case ($urandom % 7)
            0: return {8'h00, r[15:12], 4'hE, r[7:0]};
            1: return {6'h00, r[17:0]};
            2: return {6'h0F, r[17:0]};
            3: return {8'h40, r[15:0]};
            4: return {2'b00, r[21:0]};
            5: return {8'h00, r[15:12], 4'hD, 8'hFF};
            default: return r;
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state and linear mapping
        cyc(1'b1, 1'b0, 1'b0, 24'h000100, 8'h00);
        check("R9 reset ctrl", {24'd0, ctrl_dbg}, 32'd0);
        cyc(1'b1, 1'b0, 1'b0, 24'h3C0010, 8'h00);      // R6: ROM, no mirror
        cyc(1'b0, 1'b0, 1'b0, 24'h400000, 8'h00);      // R8: idle
        // R2: word write at 0x000DFF reaches page E; byte write does not
        cyc(1'b1, 1'b1, 1'b0, 24'h000DFF, 8'h81);
        cyc(1'b1, 1'b1, 1'b1, 24'h00FFFF, 8'h81);
        cyc(1'b1, 1'b0, 1'b0, 24'h000000, 8'h00);
        cyc(1'b1, 1'b1, 1'b1, 24'h000DFF, 8'h81);
        cyc(1'b1, 1'b0, 1'b0, 24'h000000, 8'h00);      // R4
        check("R2 word carry", {24'd0, ctrl_dbg}, 32'h81);
        cyc(1'b1, 1'b0, 1'b0, 24'h03FFFF, 8'h00);      // R4 top of bank
        cyc(1'b1, 1'b1, 1'b0, 24'h3C1234, 8'h00);      // R5 write to mirror
        cyc(1'b1, 1'b0, 1'b0, 24'h3FFFFF, 8'h00);      // R5
        cyc(1'b1, 1'b0, 1'b0, 24'h40FFFF, 8'h00);      // R7
        cyc(1'b1, 1'b0, 1'b0, 24'h410000, 8'h00);      // R8 outside
        cyc(1'b1, 1'b1, 1'b0, 24'h010E00, 8'h00);      // R1 above 64 KB
        // R3: lock then try to clear
        cyc(1'b1, 1'b1, 1'b0, 24'h000E01, 8'hA0);
        cyc(1'b1, 1'b1, 1'b0, 24'h000E01, 8'h00);
        cyc(1'b1, 1'b0, 1'b0, 24'h000010, 8'h00);
        check("R3 locked", {24'd0, ctrl_dbg}, 32'hA0);
        do_reset();
        cyc(1'b1, 1'b0, 1'b0, 24'h000010, 8'h00);
        check("R9 unlock by reset", {24'd0, ctrl_dbg}, 32'h00);
        // Random phase
        for (int i = 0; i < 6000; i++) begin
            logic [7:0] d;
            if (i % 150 == 149) do_reset();
            d = 8'($urandom);
            if (($urandom % 8) != 0) d[5] = 1'b0;
            cyc(($urandom % 8) != 0, $urandom % 2 == 1, $urandom % 2 == 1, rand_addr(), d);
        end
        @(negedge clk);
        check("R1 final ctrl", {24'd0, ctrl_dbg}, {24'd0, m_ctrl});
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule